// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block is a single-channel command mailbox that sits between a host processor and a secure coprocessor. The host sees a word-addressed 32-bit register window. In that window it fills sixteen argument registers, then writes a command word. That write takes a snapshot of the command and all sixteen arguments and places it in a four-entry queue. The coprocessor takes queued commands through a valid/ready pop port. When it has finished a command, it pulses a completion strobe that carries a return code and sixteen status words. The mailbox latches these results for the host and raises a completion interrupt.

A command stays pending from the moment it is accepted until its completion strobe arrives. The host reads the pending count and the coprocessor's ready flag from a queue status register. Three interrupt causes live in a write-one-to-clear cause register, and each one can be masked:
- command complete;
- submission refused because the queue was full;
- queue became full.

Top module: `cmd_mailbox`

## Requirements
- R1: Word addresses 0 to 15 (byte offsets 0x00 to 0x3C) are read/write argument registers. Each one reads back the last value written to it and resets to zero.
- R2: A write to word address 16 (byte 0x40) while fewer than 4 commands are pending queues the written command word together with the argument values present at that write. Argument writes made afterwards do not change the queued entry.
- R3: The pop port presents queued entries in submission order. pop_valid is high while the queue holds an entry. The head entry is removed on a cycle where pop_valid and pop_ready are both high. While the port is stalled, the head data stays stable.
- R4: Word address 49 (byte 0xC4) reads the pending count in bits 2:0 and cop_ready in bit 8, with all other bits zero. The pending count rises on each accepted command and falls only on an accepted completion strobe, so it never exceeds 4.
- R5: A command write while 4 commands are pending is discarded and sets cause bit 17. The pending count and the queue contents stay unchanged.
- R6: Cause bit 18 is set in the cycle in which the pending count reaches 4.
- R7: A completion strobe while the pending count is non-zero does three things: it loads done_code into the return code register (word 32, byte 0x80), it loads the sixteen status words into words 33 to 48 (bytes 0x84 to 0xC0, status word i at word 33+i), and it decrements the pending count. It also sets cause bit 0.
- R8: A completion strobe while the pending count is zero is ignored. The return code, the status words, the pending count and the cause bits all stay unchanged.
- R9: The cause register (word 50, byte 0xC8) implements only bits 0, 17 and 18, and the other bits read zero. Writing a 1 clears the matching bit, so writing back the value just read clears exactly those causes. A cause that is set in the same cycle as its clear stays set.
- R10: The mask register (word 51, byte 0xCC) implements bits 0, 17 and 18, and the other bits read zero. host_irq is high exactly when some cause bit is set and its mask bit is 0.
- R11: After reset, the cause register reads zero and the mask register reads 0x00060001. The pending count is zero, pop_valid is low and host_irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Host word address (byte offset divided by 4) |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for bus_addr, combinational |
| cop_ready | input | 1 | Coprocessor ready flag, reported in queue status |
| pop_valid | output | 1 | A queued command is available |
| pop_ready | input | 1 | Coprocessor takes the head command |
| pop_cmd | output | 32 | Head command word |
| pop_args | output | 512 | Head arguments, argument i in bits 32*i+31:32*i |
| done_strobe | input | 1 | Coprocessor finished a command |
| done_code | input | 32 | Return code carried with done_strobe |
| done_status | input | 512 | Status words, word i in bits 32*i+31:32*i |
| host_irq | output | 1 | Host interrupt request |

## Verification
The bench modifies an argument after it has been submitted. A design that captured the arguments late would deliver the changed value on the pop port. The bench also drives a fifth submission into a full queue. A design that accepted it would report the wrong pending count, and an extra command would appear after the queue drains. It fires a completion and a write-one-to-clear of the same bit in one cycle, where a design that lets the clear win would lose the completion. Finally it sends a stray completion with nothing pending, which a careless design would latch or use to wrap the counter below zero.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_ARGS = 16;
    localparam int ADDR_W   = 6;
    localparam int IDX_W    = $clog2(NUM_ARGS);

    // word addresses of the register window
    localparam int ARG_BASE    = 0;
    localparam int CMD_ADDR    = ARG_BASE + NUM_ARGS;
    localparam int RET_ADDR    = 32;
    localparam int STAT_BASE   = RET_ADDR + 1;
    localparam int QSTAT_ADDR  = STAT_BASE + NUM_ARGS;
    localparam int CAUSE_ADDR  = QSTAT_ADDR + 1;
    localparam int MASK_ADDR   = CAUSE_ADDR + 1;

    // cause / mask bit positions
    localparam int CB_DONE   = 0;
    localparam int CB_REJECT = 17;
    localparam int CB_FULL   = 18;
    localparam int READY_BIT = 8;

    localparam logic [DATA_W-1:0] CAUSE_IMPL =
        (DATA_W'(1) << CB_DONE) | (DATA_W'(1) << CB_REJECT) | (DATA_W'(1) << CB_FULL);

    typedef logic [NUM_ARGS-1:0][DATA_W-1:0] word_set_t;

    typedef struct packed {
        logic [DATA_W-1:0] cmd;
        word_set_t         args;
    } cmd_entry_t;

    function automatic logic is_addr(input logic [ADDR_W-1:0] a, input int target);
        return a == ADDR_W'(target);
    endfunction

endpackage

// File: rtl/mbx_arg_bank.sv
module mbx_arg_bank
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output word_set_t         args
);
    for (genvar g = 0; g < NUM_ARGS; g++) begin : g_arg
        always_ff @(posedge clk) begin
            if (rst)
                args[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                args[g] <= wr_data;
        end
    end
endmodule

// File: rtl/mbx_cmd_queue.sv
module mbx_cmd_queue
    import mbx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  cmd_entry_t                    push_entry,
    input  logic                          pop_ready,
    output logic                          pop_valid,
    output cmd_entry_t                    head,
    input  logic                          done,
    output logic [$clog2(DEPTH+1)-1:0]    pending,
    output logic                          push_reject,
    output logic                          full_hit,
    output logic                          done_ok
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    cmd_entry_t        slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  occ;
    logic              push_ok, pop_fire;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok     = push && (pending < CNT_W'(DEPTH));
    assign push_reject = push && !push_ok;
    assign done_ok     = done && (pending != '0);
    assign pop_valid   = occ != '0;
    assign pop_fire    = pop_valid && pop_ready;
    assign head        = slots[rd_ptr];
    assign full_hit    = push_ok && !done_ok && (pending == CNT_W'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (push_ok)
            slots[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            occ     <= '0;
            pending <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= bump(wr_ptr);
            if (pop_fire)
                rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_fire})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
            case ({push_ok, done_ok})
                2'b10:   pending <= pending + 1'b1;
                2'b01:   pending <= pending - 1'b1;
                default: pending <= pending;
            endcase
        end
    end
endmodule

// File: rtl/mbx_result_regs.sv
module mbx_result_regs
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] code_in,
    input  word_set_t         status_in,
    output logic [DATA_W-1:0] code_q,
    output word_set_t         status_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q   <= '0;
            status_q <= '0;
        end else if (load) begin
            code_q   <= code_in;
            status_q <= status_in;
        end
    end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_done,
    input  logic              set_reject,
    input  logic              set_full,
    input  logic              cause_wr,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cause_q,
    output logic [DATA_W-1:0] mask_q,
    output logic              irq
);
    logic [DATA_W-1:0] set_vec, clr_vec;

    always_comb begin
        set_vec = '0;
        set_vec[CB_DONE]   = set_done;
        set_vec[CB_REJECT] = set_reject;
        set_vec[CB_FULL]   = set_full;
        clr_vec = cause_wr ? (wdata & CAUSE_IMPL) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= CAUSE_IMPL;
        end else begin
            cause_q <= (cause_q & ~clr_vec) | set_vec;
            if (mask_wr)
                mask_q <= wdata & CAUSE_IMPL;
        end
    end

    assign irq = |(cause_q & ~mask_q);
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int QUEUE_DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic                         cop_ready,
    output logic                         pop_valid,
    input  logic                         pop_ready,
    output logic [DATA_W-1:0]            pop_cmd,
    output logic [NUM_ARGS*DATA_W-1:0]   pop_args,
    input  logic                         done_strobe,
    input  logic [DATA_W-1:0]            done_code,
    input  logic [NUM_ARGS*DATA_W-1:0]   done_status,
    output logic                         host_irq
);
    localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

    word_set_t         arg_regs, stat_regs;
    cmd_entry_t        new_entry, head_entry;
    logic [CNT_W-1:0]  pending_cnt;
    logic [DATA_W-1:0] ret_code, cause_q, mask_q;
    logic              arg_wr, cmd_wr, push_reject, full_hit, done_ok;
    logic [ADDR_W-1:0] stat_off;

    assign arg_wr = bus_we && (bus_addr < ADDR_W'(CMD_ADDR));
    assign cmd_wr = bus_we && is_addr(bus_addr, CMD_ADDR);

    mbx_arg_bank u_args (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (arg_wr),
        .wr_idx  (bus_addr[IDX_W-1:0]),
        .wr_data (bus_wdata),
        .args    (arg_regs)
    );

    assign new_entry.cmd  = bus_wdata;
    assign new_entry.args = arg_regs;

    mbx_cmd_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
        .clk         (clk),
        .rst         (rst),
        .push        (cmd_wr),
        .push_entry  (new_entry),
        .pop_ready   (pop_ready),
        .pop_valid   (pop_valid),
        .head        (head_entry),
        .done        (done_strobe),
        .pending     (pending_cnt),
        .push_reject (push_reject),
        .full_hit    (full_hit),
        .done_ok     (done_ok)
    );

    assign pop_cmd  = head_entry.cmd;
    assign pop_args = head_entry.args;

    mbx_result_regs u_result (
        .clk       (clk),
        .rst       (rst),
        .load      (done_ok),
        .code_in   (done_code),
        .status_in (done_status),
        .code_q    (ret_code),
        .status_q  (stat_regs)
    );

    mbx_irq_ctrl u_irq (
        .clk        (clk),
        .rst        (rst),
        .set_done   (done_ok),
        .set_reject (push_reject),
        .set_full   (full_hit),
        .cause_wr   (bus_we && is_addr(bus_addr, CAUSE_ADDR)),
        .mask_wr    (bus_we && is_addr(bus_addr, MASK_ADDR)),
        .wdata      (bus_wdata),
        .cause_q    (cause_q),
        .mask_q     (mask_q),
        .irq        (host_irq)
    );

    assign stat_off = bus_addr - ADDR_W'(STAT_BASE);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(CMD_ADDR))
            bus_rdata = arg_regs[bus_addr[IDX_W-1:0]];
        else if (is_addr(bus_addr, RET_ADDR))
            bus_rdata = ret_code;
        else if (bus_addr >= ADDR_W'(STAT_BASE) && bus_addr < ADDR_W'(QSTAT_ADDR))
            bus_rdata = stat_regs[stat_off[IDX_W-1:0]];
        else if (is_addr(bus_addr, QSTAT_ADDR)) begin
            bus_rdata = DATA_W'(pending_cnt);
            bus_rdata[READY_BIT] = cop_ready;
        end
        else if (is_addr(bus_addr, CAUSE_ADDR))
            bus_rdata = cause_q;
        else if (is_addr(bus_addr, MASK_ADDR))
            bus_rdata = mask_q;
    end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         bus_we,
    input logic                         pop_valid,
    input logic                         pop_ready,
    input logic [DATA_W-1:0]            pop_cmd,
    input logic [NUM_ARGS*DATA_W-1:0]   pop_args,
    input logic                         done_strobe,
    input logic                         host_irq,
    input logic [$clog2(DEPTH+1)-1:0]   pending,
    input logic [DATA_W-1:0]            cause
);
    logic cmd_wr;
    assign cmd_wr = bus_we && bus_addr == ADDR_W'(CMD_ADDR);

    // R4
    pending_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pending <= ($clog2(DEPTH+1))'(DEPTH));

    // R3
    pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pop_valid && !pop_ready |=> pop_valid && $stable(pop_cmd) && $stable(pop_args));

    // R5
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && pending == ($clog2(DEPTH+1))'(DEPTH) && !done_strobe
        |=> pending == ($clog2(DEPTH+1))'(DEPTH) && cause[CB_REJECT]);

    // R7
    done_sets_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done_strobe && pending != '0 |=> cause[CB_DONE]);

    // R8
    idle_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_strobe && pending == '0 && !cmd_wr |=> pending == '0);

    // R10
    quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
        cause == '0 |-> !host_irq);
endmodule

bind cmd_mailbox mbx_checker #(.DEPTH(QUEUE_DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .pop_valid   (pop_valid),
    .pop_ready   (pop_ready),
    .pop_cmd     (pop_cmd),
    .pop_args    (pop_args),
    .done_strobe (done_strobe),
    .host_irq    (host_irq),
    .pending     (pending_cnt),
    .cause       (cause_q)
);

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 16;

    logic          clk = 0;
    logic          rst = 1;
    logic [5:0]    bus_addr = '0;
    logic          bus_we = 0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          cop_ready = 0;
    logic          pop_valid;
    logic          pop_ready = 0;
    logic [31:0]   pop_cmd;
    logic [NA*32-1:0] pop_args;
    logic          done_strobe = 0;
    logic [31:0]   done_code = '0;
    logic [NA*32-1:0] done_status = '0;
    logic          host_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_mailbox u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cop_ready(cop_ready),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_cmd(pop_cmd),
        .pop_args(pop_args), .done_strobe(done_strobe), .done_code(done_code),
        .done_status(done_status), .host_irq(host_irq)
    );

    // {word address, data}
    localparam logic [37:0] ARG_VEC [8] = '{
        {6'd0,  32'h0000_0001}, {6'd15, 32'hFFFF_FFFF},
        {6'd7,  32'h1234_5678}, {6'd3,  32'h8000_0000},
        {6'd9,  32'hCAFE_F00D}, {6'd12, 32'h0000_0000},
        {6'd1,  32'h5A5A_A5A5}, {6'd14, 32'h7FFF_FFFE}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic load_done(input logic [31:0] code);
        done_code = code;
        for (int i = 0; i < NA; i++)
            done_status[i*32 +: 32] = 32'hB000_0000 + code * 16 + i;
    endtask

    task automatic complete(input logic [31:0] code);
        @(negedge clk);
        load_done(code);
        done_strobe = 1;
        @(negedge clk);
        done_strobe = 0;
    endtask

    task automatic pop_one();
        @(negedge clk);
        pop_ready = 1;
        @(negedge clk);
        pop_ready = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;

        // R11 reset state
        rd(50, v); chk("R11 cause", v, 32'h0);
        rd(51, v); chk("R11 mask", v, 32'h0006_0001);
        rd(49, v); chk("R11 qstat", v, 32'h0);
        chk("R11 pop_valid", {31'b0, pop_valid}, 32'h0);
        chk("R11 irq", {31'b0, host_irq}, 32'h0);

        // R1 argument table
        for (int k = 0; k < 8; k++) begin
            wr(ARG_VEC[k][37:32], ARG_VEC[k][31:0]);
            rd(ARG_VEC[k][37:32], v);
            chk("R1 arg readback", v, ARG_VEC[k][31:0]);
        end

        // R4 ready flag
        cop_ready = 1;
        rd(49, v); chk("R4 ready bit", v, 32'h0000_0100);

        // R2 snapshot on command write
        for (int i = 0; i < NA; i++) wr(6'(i), 32'hA000_0000 + i);
        wr(16, 32'h11);
        chk("R2 pop_valid", {31'b0, pop_valid}, 32'h1);
        chk("R2 pop_cmd", pop_cmd, 32'h11);
        chk("R2 arg5", pop_args[5*32 +: 32], 32'hA000_0005);
        wr(5, 32'hDEAD_BEEF);
        chk("R2 arg5 after rewrite", pop_args[5*32 +: 32], 32'hA000_0005);
        rd(49, v); chk("R4 pending 1", v, 32'h0000_0101);

        // fill queue: R6
        wr(16, 32'h12);
        wr(16, 32'h13);
        rd(50, v); chk("R6 not full yet", v, 32'h0);
        wr(16, 32'h14);
        rd(50, v); chk("R6 full cause", v, 32'h0004_0000);
        chk("R10 masked irq", {31'b0, host_irq}, 32'h0);
        wr(51, 32'h0002_0001);
        chk("R10 unmasked irq", {31'b0, host_irq}, 32'h1);

        // R5 reject
        wr(16, 32'h15);
        rd(49, v); chk("R5 pending stays 4", v, 32'h0000_0104);
        rd(50, v); chk("R5 reject cause", v, 32'h0006_0000);

        // R3 stall and pop order
        @(negedge clk);
        chk("R3 stalled head", pop_cmd, 32'h11);
        pop_one();
        chk("R3 next head", pop_cmd, 32'h12);
        rd(49, v); chk("R4 pop keeps pending", v, 32'h0000_0104);

        // R9 write back read value
        wr(50, 32'h0006_0000);
        rd(50, v); chk("R9 w1c clear", v, 32'h0);
        chk("R9 irq after clear", {31'b0, host_irq}, 32'h0);

        // R7 completion
        complete(32'h55);
        rd(32, v); chk("R7 return code", v, 32'h55);
        rd(40, v); chk("R7 status word 7", v, 32'hB000_0000 + 32'h55 * 16 + 7);
        rd(49, v); chk("R7 pending 3", v, 32'h0000_0103);
        rd(50, v); chk("R7 done cause", v, 32'h0000_0001);
        chk("R10 done masked", {31'b0, host_irq}, 32'h0);
        wr(51, 32'h0);
        chk("R10 done unmasked", {31'b0, host_irq}, 32'h1);

        // R9 set wins over clear in same cycle
        wr(50, 32'h1);
        @(negedge clk);
        load_done(32'h66);
        done_strobe = 1; bus_addr = 50; bus_wdata = 32'h1; bus_we = 1;
        @(negedge clk);
        done_strobe = 0; bus_we = 0;
        rd(50, v); chk("R9 set wins", v, 32'h0000_0001);
        rd(49, v); chk("R7 pending 2", v, 32'h0000_0102);

        // R3 / R5 drain order, rejected command absent
        pop_one();
        chk("R3 head 13", pop_cmd, 32'h13);
        pop_one();
        chk("R3 head 14", pop_cmd, 32'h14);
        pop_one();
        chk("R5 no extra entry", {31'b0, pop_valid}, 32'h0);

        complete(32'h70);
        complete(32'h77);
        rd(49, v); chk("R4 pending 0", v, 32'h0000_0100);
        wr(50, 32'hFFFF_FFFF);
        rd(50, v); chk("R9 unimplemented bits", v, 32'h0);

        // R8 stray completion
        complete(32'h99);
        rd(32, v); chk("R8 return code kept", v, 32'h77);
        rd(33, v); chk("R8 status kept", v, 32'hB000_0000 + 32'h77 * 16);
        rd(49, v); chk("R8 pending kept", v, 32'h0000_0100);
        rd(50, v); chk("R8 cause kept", v, 32'h0);

        rd(51, v); chk("R10 mask readback", v, 32'h0);
        wr(51, 32'hFFFF_FFFF);
        rd(51, v); chk("R10 mask implemented bits", v, 32'h0006_0001);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule